// File: doc/BRIEF.md
# Repeated-Subtraction Remainder Unit

This block runs the loop `while (a > b) a = a - b` in hardware and returns the value of `a` once the loop stops. When both operands are positive, the result is the remainder of `a` divided by `b`, except that it lies in the range 1 to `b` rather than 0 to `b-1`. A one-cycle `start` pulse in the idle state captures both operands. A one-cycle `done` pulse marks the cycle in which the result register is written. The result then stays on `result` until the next operation finishes.

A single adder does both the comparison and the subtraction. It forms `a + ~b + 1`. The true sign of the difference is the adder's top bit XORed with the signed overflow bit. From that sign and a zero test, the adder derives the flag "a is greater than b", which is written into a condition register. Each pass through the loop takes two control steps:

1. A compare step latches the condition.
2. A route step uses the latched condition to select between two destinations:
   - the difference goes back into the `a` register, or
   - the current `a` goes into the result register.

Top module: `rsub_loop_unit`

## Requirements
- R1: While and after a synchronous reset, `done` is 0 and `result` is 0, and `result` stays 0 until an operation completes.
- R2: A `start` pulse in the idle state captures `aIn` and `bIn` as signed two's-complement values. The `result` that follows is the value `a` reaches under `while (a > b) a = a - b` with signed comparison.
- R3: When the captured operands are equal, the loop ends without a subtraction and `result` equals `aIn`.
- R4: When `aIn` is less than `bIn`, `result` equals `aIn` unchanged.
- R5: Take the cycle whose rising edge samples `start` as cycle 1, and let k be the number of subtractions performed. Then `done` is high during cycle 2k+3. Each loop pass is a compare step followed by a route step.
- R6: `done` is high for exactly one cycle. `result` keeps its value after `done` falls until the next operation completes.
- R7: A `start` pulse while an operation is in progress is ignored. Neither the result nor the latency of the running operation changes.
- R8: The comparison uses the sign of the difference corrected by signed overflow. For example, with W=16, aIn=-30000 and bIn=30000 give result -30000 with no subtraction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request that captures the operands when idle |
| aIn | input | W | Dividend operand, signed |
| bIn | input | W | Divisor operand, signed |
| done | output | 1 | One-cycle pulse when the result register is written |
| result | output | W | Final value of a, held between operations |

## Verification
The assertion that every loop pass strictly lowers `a` takes for granted that the divisor is positive. With zero or a negative divisor the loop either never ends or wraps around, and both cases are outside the block's scope. The random stimulus draws divisors from 1 up to half the positive range. It picks dividends whose quotient stays small, so runs remain short. Directed cases add the following:
- a divisor of one with a large dividend;
- equal operands;
- a negative dividend;
- a pair of operands whose raw difference overflows.

// File: rtl/rsub_pkg.sv
package rsub_pkg;

  typedef struct packed {
    logic load;   // capture operands, clear condition
    logic cmp;    // latch a > b into the condition register
    logic route;  // steer a by the condition: loop or final
  } rsub_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMP  = 2'd1,
    ST_STEP = 2'd2
  } rsub_state_t;

endpackage

// File: rtl/rsub_adder.sv
module rsub_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] diff,
  output logic         gtFlag
);
  localparam int MSB = W - 1;

  logic [W:0] sumExt;
  logic       ovf;
  logic       neg;
  logic       isZero;

  // One adder: a + ~b with carry-in 1
  always_comb begin
    sumExt = {1'b0, opA} + {1'b0, ~opB} + {{W{1'b0}}, 1'b1};
    diff   = sumExt[W-1:0];
    ovf    = (opA[MSB] != opB[MSB]) && (diff[MSB] != opA[MSB]);
    neg    = diff[MSB] ^ ovf;
    isZero = (diff == '0);
    gtFlag = !neg && !isZero;
  end

endmodule

// File: rtl/rsub_datapath.sv
module rsub_datapath
  import rsub_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  rsub_strobe_t strobe,
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  output logic         cond,
  output logic         doneQ,
  output logic [W-1:0] resQ
);
  logic [W-1:0] aQ;
  logic [W-1:0] bQ;
  logic         r1Q;
  logic [W-1:0] diff;
  logic         gtFlag;

  rsub_adder #(.W(W)) u_adder (
    .opA   (aQ),
    .opB   (bQ),
    .diff  (diff),
    .gtFlag(gtFlag)
  );

  // Operand and condition registers
  always_ff @(posedge clk) begin
    if (rst) begin
      aQ  <= '0;
      bQ  <= '0;
      r1Q <= 1'b0;
    end else begin
      if (strobe.load) begin
        aQ  <= aIn;
        bQ  <= bIn;
        r1Q <= 1'b0;
      end else begin
        if (strobe.cmp) r1Q <= gtFlag;
        if (strobe.route && r1Q) aQ <= diff;   // demux: loop branch
      end
    end
  end

  // Final register and done pulse: demux false branch
  always_ff @(posedge clk) begin
    if (rst) begin
      resQ  <= '0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= strobe.route && !r1Q;
      if (strobe.route && !r1Q) resQ <= aQ;
    end
  end

  assign cond = r1Q;

  AST_A_SHRINKS: assert property (@(posedge clk) disable iff (rst)
    (strobe.route && r1Q) |=> ($signed(aQ) < $signed($past(aQ)))); // R2
  AST_FINAL_BOUND: assert property (@(posedge clk) disable iff (rst)
    doneQ |-> !($signed(resQ) > $signed(bQ))); // R2
  AST_B_HELD: assert property (@(posedge clk) disable iff (rst)
    !strobe.load |=> (bQ == $past(bQ))); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    doneQ |=> !doneQ); // R6
  AST_RES_HELD: assert property (@(posedge clk) disable iff (rst)
    !doneQ |-> (resQ == $past(resQ))); // R6

endmodule

// File: rtl/rsub_control.sv
module rsub_control
  import rsub_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         cond,
  output rsub_strobe_t strobe
);
  rsub_state_t state;
  rsub_state_t stateNext;

  always_comb begin
    stateNext    = state;
    strobe       = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.load = 1'b1;
          stateNext   = ST_CMP;
        end
      end
      ST_CMP: begin
        strobe.cmp = 1'b1;
        stateNext  = ST_STEP;
      end
      ST_STEP: begin
        strobe.route = 1'b1;
        stateNext    = cond ? ST_CMP : ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.load, strobe.cmp, strobe.route})); // R5
  AST_CMP_THEN_ROUTE: assert property (@(posedge clk) disable iff (rst)
    strobe.cmp |=> strobe.route); // R5
  AST_LOAD_THEN_CMP: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> strobe.cmp); // R5
  AST_BUSY_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> !strobe.load); // R7

endmodule

// File: rtl/rsub_loop_unit.sv
module rsub_loop_unit
  import rsub_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  output logic         done,
  output logic [W-1:0] result
);
  rsub_strobe_t strobe;
  logic         cond;

  rsub_control u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .cond  (cond),
    .strobe(strobe)
  );

  rsub_datapath #(.W(W)) u_dp (
    .clk   (clk),
    .rst   (rst),
    .strobe(strobe),
    .aIn   (aIn),
    .bIn   (bIn),
    .cond  (cond),
    .doneQ (done),
    .resQ  (result)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!done && result == '0)); // R1

endmodule

// File: tb/rsub_loop_unit_tb.sv
module rsub_loop_unit_tb;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] aIn = '0;
  logic [W-1:0] bIn = '0;
  logic         done;
  logic [W-1:0] result;

  int checks = 0;
  int errors = 0;
  int cycleCount = 0;

  rsub_loop_unit #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .aIn(aIn), .bIn(bIn),
    .done(done), .result(result)
  );

  always #4 clk = ~clk;   // 125 MHz

  always @(posedge clk) begin
    cycleCount <= cycleCount + 1;
    if (cycleCount > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Requirement model: subtractions count and final a for b > 0
  function automatic int subCount(input int a, input int b);
    if (a > b) return (a - 1) / b;
    return 0;
  endfunction

  function automatic int finalA(input int a, input int b);
    return a - subCount(a, b) * b;
  endfunction

  // Runs one operation; optional busy start pulse at cycle 4 with junk operands
  task automatic runOp(input string tag, input int a, input int b, input bit poke);
    int k;
    int cyc;
    int sv;
    k = (b > 0) ? subCount(a, b) : 0;
    @(negedge clk);
    aIn = a[W-1:0];
    bIn = b[W-1:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 70000) begin
      if (poke && cyc == 4) begin
        aIn = 16'd7;
        bIn = 16'd5;
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check({tag, " R2 result"}, $signed(result), finalA(a, b));
    check({tag, " R5 latency"}, cyc, 2 * k + 3);
    sv = $signed(result);
    @(negedge clk);
    check({tag, " R6 done pulse"}, done, 0);
    @(negedge clk);
    @(negedge clk);
    check({tag, " R6 result held"}, $signed(result), sv);
  endtask

  initial begin
    void'($urandom(565));
    repeat (3) @(negedge clk);
    check("R1 done in reset", done, 0);
    check("R1 result in reset", result, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 done after reset", done, 0);
    check("R1 result after reset", result, 0);

    runOp("R2 basic 100%7", 100, 7, 1'b0);
    runOp("R3 equal", 250, 250, 1'b0);
    runOp("R4 a<b", 3, 40, 1'b0);
    runOp("R2 exact multiple", 90, 9, 1'b0);
    runOp("R2 b=1", 1000, 1, 1'b0);
    runOp("R8 negative a", -5, 3, 1'b0);
    runOp("R8 overflow pair", -30000, 30000, 1'b0);
    runOp("R8 max positive", 32767, 16384, 1'b0);
    runOp("R7 busy start", 500, 11, 1'b1);
    runOp("R7 after busy", 29, 6, 1'b0);

    for (int i = 0; i < 40; i++) begin
      int b;
      int a;
      b = 1 + int'($urandom_range(16383));
      a = int'($urandom_range(32767));
      if (a / b > 60) a = a % (b * 60 + 1);
      runOp("R2 random", a, b, (i % 8) == 3);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule